// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave

This block is the slave side of a two-wire serial memory. The open-drain bus is oversampled by the system clock. The block finds START and STOP conditions and answers a device address whose upper nibble is the fixed type code 1010 and whose next three bits match three strap inputs. As a result, up to eight such slaves can share one bus. Behind the bus logic there is a byte-wide storage array and a word address counter that spans 32K bytes.

A write transaction carries two word-address bytes and then one or more data bytes. The data bytes collect in a 64-entry page buffer. Nothing reaches the array until the master sends STOP. The STOP starts a timed write cycle, and its length is a parameter given in clock cycles. While that cycle runs, the block refuses its own device address. A write-protect input suppresses the write cycle completely.

Reads come in three forms: from the current counter value, from an address loaded by a dummy write followed by a repeated START, or as a sequential stream from either. The storage depth is a separate parameter. The bus address always counts over the full 15 bits, and the storage decodes its low bits.

Top module: `i2c_eeprom`

## Requirements
- R1: The device byte is {4'b1010, strap_i[2:0], R/W} with MSB first and R/W=1 meaning read. On a match the slave pulls SDA low in the 9th clock. On a mismatch it never pulls SDA until the next START.
- R2: After a write-mode device byte, two address bytes are acknowledged, high byte first. Bit 7 of the high byte is ignored, so 0x81,0x23 addresses location 0x0123.
- R3: Data bytes in a write are acknowledged, and after STOP the location reads back the written value.
- R4: In a write, only the low 6 address bits advance after each data byte. A 65th and 66th byte therefore overwrite the first two bytes of the same 64-byte page.
- R5: For WR_CYCLES clock cycles after a STOP that ends a write with data, the device byte is not acknowledged.
- R6: While wp_i is high at STOP, data bytes are still acknowledged, but no write cycle starts: the array keeps its old value and the next device byte is acknowledged at once.
- R7: A random read (address write, repeated START, read-mode device byte) returns the byte at the loaded address.
- R8: Sequential reads advance the full 15-bit address, rolling over from 0x7FFF to 0x0000.
- R9: A read-mode device byte without a preceding address returns the byte after the last one accessed.
- R10: After the master answers a read byte with NACK, the slave releases SDA and drives nothing until a START.
- R11: SDA changes only after an SCL falling edge, a START or a STOP.
- R12: After reset, SDA is released and the device byte is acknowledged.
- R13: A START that arrives before STOP abandons the buffered page, and no write cycle follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_pull_o | output | 1 | 1 pulls the data line low |
| strap_i | input | 3 | Device address strap bits |
| wp_i | input | 1 | Array write lock, active high |

## Verification
The bench keeps the default 15-bit bus address, the 6-bit page and 2K bytes of storage. It shortens WR_CYCLES to 1000, which is still longer than one device byte on the bus. With that value, a device byte sent right after STOP falls inside the busy window and must be refused, and waiting out a write cycle costs little. Each bus quarter-bit lasts 8 clocks, so the synchronizer delay never races the master's data changes.

// File: rtl/eeprom_pkg.sv
package eeprom_pkg;

    localparam logic [3:0] DEV_TYPE = 4'b1010;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DEV,
        ST_AHI,
        ST_ALO,
        ST_WDAT,
        ST_RDAT,
        ST_IGNORE
    } ctrl_state_t;

    typedef struct packed {
        logic start;
        logic stop;
        logic rise;
        logic fall;
        logic sda;
    } bus_ev_t;

    function automatic logic dev_match(input logic [7:0] b, input logic [2:0] strap);
        return b[7:1] == {DEV_TYPE, strap};
    endfunction

endpackage

// File: rtl/i2c_line_sense.sv
module i2c_line_sense
    import eeprom_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_i,
    input  logic    sda_i,
    output bus_ev_t ev_o
);
    logic [1:0] scl_sync, sda_sync;
    logic       scl_prev, sda_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_sync <= 2'b11;
            sda_sync <= 2'b11;
            scl_prev <= 1'b1;
            sda_prev <= 1'b1;
        end else begin
            scl_sync <= {scl_sync[0], scl_i};
            sda_sync <= {sda_sync[0], sda_i};
            scl_prev <= scl_sync[1];
            sda_prev <= sda_sync[1];
        end
    end

    always_comb begin
        ev_o.sda   = sda_sync[1];
        ev_o.rise  = scl_sync[1] & ~scl_prev;
        ev_o.fall  = ~scl_sync[1] & scl_prev;
        ev_o.start = scl_sync[1] & scl_prev & sda_prev & ~sda_sync[1];
        ev_o.stop  = scl_sync[1] & scl_prev & ~sda_prev & sda_sync[1];
    end
endmodule

// File: rtl/eeprom_core.sv
module eeprom_core #(
    parameter int ADDR_W    = 15,
    parameter int MEM_AW    = 11,
    parameter int PAGE_AW   = 6,
    parameter int WR_CYCLES = 600000
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      wp_i,
    input  logic                      buf_clr_i,
    input  logic                      buf_we_i,
    input  logic [PAGE_AW-1:0]        buf_idx_i,
    input  logic [7:0]                buf_din_i,
    input  logic                      commit_i,
    input  logic [ADDR_W-PAGE_AW-1:0] commit_page_i,
    input  logic [ADDR_W-1:0]         rd_addr_i,
    output logic [7:0]                rd_data_o,
    output logic                      busy_o
);
    localparam int PAGE  = 1 << PAGE_AW;
    localparam int DEPTH = 1 << MEM_AW;
    localparam int CW    = $clog2(WR_CYCLES + 1);

    logic [7:0]                pbuf [PAGE];
    logic [7:0]                mem  [DEPTH];
    logic [PAGE-1:0]           pmask;
    logic [CW-1:0]             cnt;
    logic [ADDR_W-PAGE_AW-1:0] cpage;
    logic [ADDR_W-1:0]         wr_full;
    logic [PAGE_AW-1:0]        cnt_lo;
    logic                      mem_we;

    assign cnt_lo  = cnt[PAGE_AW-1:0];
    assign wr_full = {cpage, cnt_lo};
    assign mem_we  = busy_o && (cnt < CW'(PAGE)) && pmask[cnt_lo];
    assign rd_data_o = mem[rd_addr_i[MEM_AW-1:0]];

    always_ff @(posedge clk) begin
        if (rst) begin
            pmask  <= '0;
            busy_o <= 1'b0;
            cnt    <= '0;
            cpage  <= '0;
        end else begin
            if (buf_clr_i) pmask <= '0;
            else if (buf_we_i) pmask[buf_idx_i] <= 1'b1;
            if (commit_i) begin
                busy_o <= 1'b1;
                cnt    <= '0;
                cpage  <= commit_page_i;
            end else if (busy_o) begin
                cnt <= cnt + 1'b1;
                if (cnt == CW'(WR_CYCLES - 1)) busy_o <= 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (buf_we_i) pbuf[buf_idx_i] <= buf_din_i;
        if (mem_we) mem[wr_full[MEM_AW-1:0]] <= pbuf[cnt_lo];
    end

    AST_COMMIT_UNLOCKED: assert property (@(posedge clk) disable iff (rst)
        commit_i |-> !wp_i); // R6
    AST_COMMIT_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
        commit_i |-> !busy_o); // R5
    AST_BUSY_FULL_LENGTH: assert property (@(posedge clk) disable iff (rst)
        $fell(busy_o) |-> $past(cnt) == CW'(WR_CYCLES - 1)); // R5
endmodule

// File: rtl/eeprom_ctrl.sv
module eeprom_ctrl
    import eeprom_pkg::*;
#(
    parameter int ADDR_W  = 15,
    parameter int PAGE_AW = 6
) (
    input  logic                      clk,
    input  logic                      rst,
    input  bus_ev_t                   ev_i,
    input  logic [2:0]                strap_i,
    input  logic                      wp_i,
    input  logic                      busy_i,
    input  logic [7:0]                rd_data_i,
    output logic [ADDR_W-1:0]         addr_o,
    output logic                      sda_pull_o,
    output logic                      buf_clr_o,
    output logic                      buf_we_o,
    output logic [PAGE_AW-1:0]        buf_idx_o,
    output logic [7:0]                buf_din_o,
    output logic                      commit_o,
    output logic [ADDR_W-PAGE_AW-1:0] commit_page_o
);
    ctrl_state_t state_q;
    logic [3:0]  bitcnt;
    logic [7:0]  sh, tx;
    logic        in_ack, rw, have_data, byte_end, dev_hit, quiet;

    assign quiet    = !ev_i.start && !ev_i.stop;
    assign byte_end = quiet && ev_i.fall && !in_ack && bitcnt == 4'd8;
    assign dev_hit  = dev_match(sh, strap_i) && !busy_i;

    assign buf_we_o      = byte_end && state_q == ST_WDAT;
    assign buf_clr_o     = byte_end && state_q == ST_DEV && dev_hit && !sh[0];
    assign buf_idx_o     = addr_o[PAGE_AW-1:0];
    assign buf_din_o     = sh;
    assign commit_o      = ev_i.stop && have_data && !wp_i && !busy_i;
    assign commit_page_o = addr_o[ADDR_W-1:PAGE_AW];

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_IDLE;
            bitcnt     <= '0;
            sh         <= '0;
            tx         <= '0;
            in_ack     <= 1'b0;
            rw         <= 1'b0;
            have_data  <= 1'b0;
            addr_o     <= '0;
            sda_pull_o <= 1'b0;
        end else if (ev_i.start) begin
            state_q    <= ST_DEV;
            bitcnt     <= '0;
            in_ack     <= 1'b0;
            have_data  <= 1'b0;
            sda_pull_o <= 1'b0;
        end else if (ev_i.stop) begin
            state_q    <= ST_IDLE;
            in_ack     <= 1'b0;
            have_data  <= 1'b0;
            sda_pull_o <= 1'b0;
        end else begin
            case (state_q)
                ST_DEV, ST_AHI, ST_ALO, ST_WDAT: begin
                    if (ev_i.rise && bitcnt < 4'd8) begin
                        sh     <= {sh[6:0], ev_i.sda};
                        bitcnt <= bitcnt + 1'b1;
                    end
                    if (ev_i.fall && in_ack) begin
                        sda_pull_o <= 1'b0;
                        in_ack     <= 1'b0;
                        bitcnt     <= '0;
                        case (state_q)
                            ST_DEV: begin
                                if (rw) begin
                                    state_q    <= ST_RDAT;
                                    tx         <= rd_data_i;
                                    addr_o     <= addr_o + 1'b1;
                                    sda_pull_o <= ~rd_data_i[7];
                                end else begin
                                    state_q <= ST_AHI;
                                end
                            end
                            ST_AHI:  state_q <= ST_ALO;
                            ST_ALO:  state_q <= ST_WDAT;
                            default: state_q <= state_q;
                        endcase
                    end else if (byte_end) begin
                        sda_pull_o <= 1'b1;
                        in_ack     <= 1'b1;
                        case (state_q)
                            ST_DEV: begin
                                if (dev_hit) rw <= sh[0];
                                else begin
                                    state_q    <= ST_IGNORE;
                                    sda_pull_o <= 1'b0;
                                    in_ack     <= 1'b0;
                                end
                            end
                            ST_AHI: addr_o[ADDR_W-1:8] <= sh[ADDR_W-9:0];
                            ST_ALO: addr_o[7:0] <= sh;
                            default: begin
                                addr_o[PAGE_AW-1:0] <= addr_o[PAGE_AW-1:0] + 1'b1;
                                have_data <= 1'b1;
                            end
                        endcase
                    end
                end
                ST_RDAT: begin
                    if (ev_i.rise) begin
                        if (bitcnt == 4'd8) begin
                            if (ev_i.sda) state_q <= ST_IGNORE;
                            else          bitcnt  <= 4'd9;
                        end else begin
                            bitcnt <= bitcnt + 1'b1;
                        end
                    end
                    if (ev_i.fall) begin
                        if (bitcnt == 4'd9) begin
                            tx         <= rd_data_i;
                            addr_o     <= addr_o + 1'b1;
                            sda_pull_o <= ~rd_data_i[7];
                            bitcnt     <= '0;
                        end else if (bitcnt == 4'd8) begin
                            sda_pull_o <= 1'b0;
                        end else if (bitcnt != 4'd0) begin
                            sda_pull_o <= ~tx[3'd7 - bitcnt[2:0]];
                        end
                    end
                end
                default: sda_pull_o <= 1'b0;
            endcase
        end
    end

    AST_SDA_MOVES_LOW: assert property (@(posedge clk) disable iff (rst)
        !$stable(sda_pull_o) |-> $past(ev_i.fall || ev_i.start || ev_i.stop)); // R11
    AST_IGNORE_QUIET: assert property (@(posedge clk) disable iff (rst)
        state_q == ST_IGNORE |-> !sda_pull_o); // R1
    AST_BUSY_NO_ACK: assert property (@(posedge clk) disable iff (rst)
        (byte_end && state_q == ST_DEV && busy_i) |=> !sda_pull_o); // R5
    AST_PAGE_HELD: assert property (@(posedge clk) disable iff (rst)
        buf_we_o |=> addr_o[ADDR_W-1:PAGE_AW] == $past(addr_o[ADDR_W-1:PAGE_AW])); // R4
endmodule

// File: rtl/i2c_eeprom.sv
module i2c_eeprom #(
    parameter int ADDR_W    = 15,
    parameter int MEM_AW    = 11,
    parameter int PAGE_AW   = 6,
    parameter int WR_CYCLES = 600000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_pull_o,
    input  logic [2:0] strap_i,
    input  logic       wp_i
);
    import eeprom_pkg::*;

    bus_ev_t                   ev;
    logic                      busy, buf_clr, buf_we, commit;
    logic [PAGE_AW-1:0]        buf_idx;
    logic [7:0]                buf_din, rd_data;
    logic [ADDR_W-PAGE_AW-1:0] commit_page;
    logic [ADDR_W-1:0]         addr;

    i2c_line_sense u_sense (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .ev_o  (ev)
    );

    eeprom_ctrl #(.ADDR_W(ADDR_W), .PAGE_AW(PAGE_AW)) u_ctrl (
        .clk           (clk),
        .rst           (rst),
        .ev_i          (ev),
        .strap_i       (strap_i),
        .wp_i          (wp_i),
        .busy_i        (busy),
        .rd_data_i     (rd_data),
        .addr_o        (addr),
        .sda_pull_o    (sda_pull_o),
        .buf_clr_o     (buf_clr),
        .buf_we_o      (buf_we),
        .buf_idx_o     (buf_idx),
        .buf_din_o     (buf_din),
        .commit_o      (commit),
        .commit_page_o (commit_page)
    );

    eeprom_core #(.ADDR_W(ADDR_W), .MEM_AW(MEM_AW), .PAGE_AW(PAGE_AW),
                  .WR_CYCLES(WR_CYCLES)) u_core (
        .clk           (clk),
        .rst           (rst),
        .wp_i          (wp_i),
        .buf_clr_i     (buf_clr),
        .buf_we_i      (buf_we),
        .buf_idx_i     (buf_idx),
        .buf_din_i     (buf_din),
        .commit_i      (commit),
        .commit_page_i (commit_page),
        .rd_addr_i     (addr),
        .rd_data_o     (rd_data),
        .busy_o        (busy)
    );
endmodule

// File: tb/i2c_eeprom_tb.sv
module i2c_eeprom_tb;
    localparam int WRC   = 1000;
    localparam int Q     = 8;
    localparam logic [2:0] STRAP = 3'b101;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl = 1'b1;
    logic m_sda = 1'b1;
    logic wp = 1'b0;
    logic sda_pull;
    logic sda_line;
    logic mon_en = 1'b0;
    logic mon_seen = 1'b0;
    int   checks = 0;
    int   errors = 0;
    int   cycles = 0;
    logic [7:0] rbuf [64];

    always #4 clk = ~clk;
    assign sda_line = m_sda & ~sda_pull;

    i2c_eeprom #(.WR_CYCLES(WRC)) u_dut (
        .clk        (clk),
        .rst        (rst),
        .scl_i      (scl),
        .sda_i      (sda_line),
        .sda_pull_o (sda_pull),
        .strap_i    (STRAP),
        .wp_i       (wp)
    );

    always @(posedge clk) if (mon_en && sda_pull) mon_seen <= 1'b1;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles == 190000) begin
            errors = errors + 1;
            checks = checks + 1;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wq(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; wq(Q); scl = 1'b1; wq(Q);
        m_sda = 1'b0; wq(Q); scl = 1'b0; wq(Q);
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; wq(Q); scl = 1'b1; wq(Q); m_sda = 1'b1; wq(2 * Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            m_sda = b[i]; wq(Q); scl = 1'b1; wq(2 * Q); scl = 1'b0; wq(Q);
        end
        m_sda = 1'b1; wq(Q); scl = 1'b1; wq(Q);
        ack = ~sda_line;
        wq(Q); scl = 1'b0; wq(Q);
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] b);
        m_sda = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            wq(Q); scl = 1'b1; wq(Q); b[i] = sda_line; wq(Q); scl = 1'b0; wq(Q);
        end
        m_sda = ~give_ack; wq(Q); scl = 1'b1; wq(2 * Q); scl = 1'b0; wq(Q);
        m_sda = 1'b1;
    endtask

    task automatic set_addr(input logic [7:0] hi, input logic [7:0] lo, input string req);
        logic a;
        bus_start();
        send_byte({4'b1010, STRAP, 1'b0}, a); chk(a, req, a, 1);
        send_byte(hi, a); chk(a, "R2 high", a, 1);
        send_byte(lo, a); chk(a, "R2 low", a, 1);
    endtask

    task automatic read_seq(input logic [7:0] hi, input logic [7:0] lo, input int n);
        logic a;
        set_addr(hi, lo, "R7 dummy write");
        bus_start();
        send_byte({4'b1010, STRAP, 1'b1}, a); chk(a, "R7 read dev", a, 1);
        for (int k = 0; k < n; k++) recv_byte(k != n - 1, rbuf[k]);
        wq(Q);
        chk(!sda_pull, "R10 release", sda_pull, 0);
        bus_stop();
    endtask

    task automatic t_reset();
        chk(!sda_pull, "R12 sda idle", sda_pull, 0);
    endtask

    task automatic t_single_write();
        logic a;
        set_addr(8'h01, 8'h23, "R1 dev ack");
        send_byte(8'hA5, a); chk(a, "R3 data ack", a, 1);
        bus_stop();
        bus_start();
        send_byte({4'b1010, STRAP, 1'b0}, a); chk(!a, "R5 busy nack", a, 0);
        bus_stop();
        wq(WRC + 20);
        read_seq(8'h01, 8'h23, 1);
        chk(rbuf[0] == 8'hA5, "R3 R7 readback", rbuf[0], 8'hA5);
    endtask

    task automatic t_msb_ignored();
        logic a;
        set_addr(8'h81, 8'h23, "R2 dev");
        send_byte(8'h77, a); chk(a, "R3 data ack", a, 1);
        bus_stop();
        wq(WRC + 20);
        read_seq(8'h01, 8'h23, 1);
        chk(rbuf[0] == 8'h77, "R2 msb ignored", rbuf[0], 8'h77);
    endtask

    task automatic t_page_wrap();
        logic a;
        logic [7:0] e;
        set_addr(8'h00, 8'h40, "R4 dev");
        for (int i = 0; i < 66; i++) begin
            send_byte(8'(8'h10 + i), a);
            if (i == 65) chk(a, "R4 66th ack", a, 1);
        end
        bus_stop();
        wq(WRC + 20);
        read_seq(8'h00, 8'h40, 64);
        for (int k = 0; k < 64; k++) begin
            e = (k < 2) ? 8'(8'h50 + k) : 8'(8'h10 + k);
            chk(rbuf[k] == e, "R4 page wrap", rbuf[k], e);
        end
    endtask

    task automatic t_abort_on_start();
        logic a;
        set_addr(8'h01, 8'h23, "R13 dev");
        send_byte(8'h99, a);
        bus_start();
        send_byte({4'b1010, STRAP, 1'b0}, a); chk(a, "R13 no busy", a, 1);
        bus_stop();
        wq(WRC + 20);
        read_seq(8'h01, 8'h23, 1);
        chk(rbuf[0] == 8'h77, "R13 page dropped", rbuf[0], 8'h77);
    endtask

    task automatic t_rollover();
        logic a;
        logic [7:0] b;
        set_addr(8'h7F, 8'hFF, "R8 dev");
        send_byte(8'hC1, a); bus_stop(); wq(WRC + 20);
        set_addr(8'h00, 8'h00, "R8 dev");
        send_byte(8'hD0, a); send_byte(8'hD1, a); bus_stop(); wq(WRC + 20);
        read_seq(8'h7F, 8'hFF, 2);
        chk(rbuf[0] == 8'hC1, "R8 last byte", rbuf[0], 8'hC1);
        chk(rbuf[1] == 8'hD0, "R8 rollover", rbuf[1], 8'hD0);
        bus_start();
        send_byte({4'b1010, STRAP, 1'b1}, a); chk(a, "R9 dev ack", a, 1);
        recv_byte(1'b0, b);
        chk(b == 8'hD1, "R9 current addr", b, 8'hD1);
        bus_stop();
    endtask

    task automatic t_mismatch();
        logic a;
        int acks = 0;
        mon_seen = 1'b0;
        mon_en = 1'b1;
        bus_start();
        send_byte({4'b1010, 3'b010, 1'b0}, a); chk(!a, "R1 mismatch nack", a, 0);
        send_byte(8'h01, a); acks += int'(a);
        send_byte(8'h23, a); acks += int'(a);
        send_byte(8'h55, a); acks += int'(a);
        bus_stop();
        mon_en = 1'b0;
        chk(acks == 0, "R1 ignored acks", acks, 0);
        chk(!mon_seen, "R1 sda never driven", mon_seen, 0);
        bus_start();
        send_byte({4'b1010, STRAP, 1'b0}, a); chk(a, "R1 match after", a, 1);
        bus_stop();
        read_seq(8'h01, 8'h23, 1);
        chk(rbuf[0] == 8'h77, "R1 array untouched", rbuf[0], 8'h77);
    endtask

    task automatic t_write_protect();
        logic a;
        wp = 1'b1;
        set_addr(8'h01, 8'h23, "R6 dev");
        send_byte(8'h3C, a); chk(a, "R6 data ack", a, 1);
        bus_stop();
        bus_start();
        send_byte({4'b1010, STRAP, 1'b0}, a); chk(a, "R6 not busy", a, 1);
        bus_stop();
        wp = 1'b0;
        read_seq(8'h01, 8'h23, 1);
        chk(rbuf[0] == 8'h77, "R6 array kept", rbuf[0], 8'h77);
    endtask

    initial begin
        wq(5);
        rst = 1'b0;
        wq(5);
        t_reset();
        t_single_write();
        t_msb_ignored();
        t_page_wrap();
        t_abort_on_start();
        t_rollover();
        t_mismatch();
        t_write_protect();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule